// File: doc/BRIEF.md
# Adaptive EPROM Location Programmer

This block is the host-side sequencer that writes one word into an EPROM target by an adaptive pulse method. A single `start` strobe hands it the word to be written and the pulse budget. It first confirms that the cell is still erased at the lowest supply level. It then applies fixed-length write pulses at the programming supply level, reading the word back after every pulse. The number of pulses the cell needed sets the size of an over-programming burst. A final read-back at the low supply level and then at the high one confirms retention margin.

The analog supply is not part of the block. It is driven as a two-bit level code, and the sequencer waits a parameterised settle time after every change of that code before it reads or pulses. Reads travel over a plain request/response pair: a one-cycle `rd_req` goes out, and the answer is taken whenever `rd_valid` comes back, with any latency. At the end of each location, `done` rises for one cycle together with a two-bit result code.

Top module: `eprom_prog_seq`

## Requirements
- R1: The first target read of every location is a blank check taken at level code 0 (minimum). The check passes only when every data bit reads 1. On a failure the location ends with result code 1, and no write pulse is issued.
- R2: Write pulses are issued only at level code 1 (programming). Each pulse is exactly `PULSE_CYC` cycles of `prog_pulse` high, with at least one low cycle between pulses. Every non-margin pulse is followed by one verify read at level code 1, compared against the latched word.
- R3: Once the pulse count reaches the limit and the verify read still mismatches, the location ends with result code 2. The limit is 25 when `cfg_word` was 0 at start and 100 when it was 1, so exactly the limit number of pulses has been issued.
- R4: If the verify read matches after N pulses, exactly 3×N more margin pulses are issued, with no read between them. A location that passes therefore sees 4×N pulses in total.
- R5: After the margin pulses, one read is taken at level code 0 and then one at level code 2 (maximum). A mismatch at the minimum ends the location with result code 3 and no read at the maximum. A mismatch at the maximum also gives result code 3. Matches at both give result code 0, with the level left at code 2.
- R6: No read request and no pulse start occurs until at least `SETTLE_CYC` cycles after a change of `supply_lvl`.
- R7: `done` is high for exactly one cycle per location. `err_code` carries the result in that cycle and reads 0 at all other times.
- R8: `rd_req` is a one-cycle strobe that never coincides with `prog_pulse`.
- R9: A `start` strobe while `busy` is high is ignored. Changes of `cfg_word` or `exp_data` after the accepting strobe have no effect on the location in progress.
- R10: Out of reset, `supply_lvl` is 0 and `busy`, `done`, `prog_pulse`, `rd_req` and `err_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one location (taken only when idle) |
| cfg_word | input | 1 | 1 selects the 100-pulse budget, 0 the 25-pulse budget |
| exp_data | input | DATA_W | Word to be written |
| supply_lvl | output | 2 | Supply level code: 0 minimum, 1 programming, 2 maximum |
| prog_pulse | output | 1 | Write pulse to the target |
| rd_req | output | 1 | One-cycle read request |
| rd_valid | input | 1 | Read answer is present |
| rd_data | input | DATA_W | Word read from the target |
| busy | output | 1 | A location is in progress |
| done | output | 1 | One-cycle end-of-location strobe |
| err_code | output | 2 | Result: 0 ok, 1 not blank, 2 would not program, 3 margin read failed |

## Verification
The result of a location appears one cycle after the cycle in which the deciding `rd_valid` is high. The state register takes the answer at that edge, and `done` follows from it. A level change becomes visible one cycle after the decision that makes it. The matching read request or pulse then comes `SETTLE_CYC` edges later, and a pulse holds for `PULSE_CYC` cycles. The bench samples every output on falling edges and follows each location edge by edge. It counts pulse widths and the age of the level at each request and pulse start. It compares pulse totals, read counts and read levels against the arithmetic expectation for the cell's pulse requirement, sweeping that requirement across both budgets and past each limit.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

  typedef enum logic [1:0] {
    LVL_MIN  = 2'd0,
    LVL_PROG = 2'd1,
    LVL_MAX  = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_BLANK  = 2'd1,
    ERR_UNPROG = 2'd2,
    ERR_MARGIN = 2'd3
  } err_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SET_BLANK,
    ST_RD_BLANK,
    ST_SET_PROG,
    ST_PULSE,
    ST_RD_VFY,
    ST_MRG_PULSE,
    ST_MRG_GAP,
    ST_SET_MIN,
    ST_RD_MIN,
    ST_SET_MAX,
    ST_RD_MAX,
    ST_DONE
  } st_e;

endpackage

// File: rtl/eprom_seq_timer.sv
module eprom_seq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/eprom_seq_tally.sv
module eprom_seq_tally #(
  parameter int CNT_W      = 7,
  parameter int MRG_W      = 9,
  parameter int MARGIN_MUL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             mrg_load,
  input  logic             mrg_dec,
  output logic [CNT_W-1:0] cnt,
  output logic             mrg_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [MRG_W-1:0] mrg_q, mrg_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    mrg_d = mrg_q;
    if (mrg_load)                   mrg_d = MRG_W'(cnt_q * MARGIN_MUL);
    else if (mrg_dec && mrg_q != '0) mrg_d = mrg_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mrg_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      mrg_q <= mrg_d;
    end
  end

  assign cnt      = cnt_q;
  assign mrg_zero = (mrg_q == '0);
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_seq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PULSE_CYC  = 2000,
  parameter int SETTLE_CYC = 64,
  parameter int LIMIT_STD  = 25,
  parameter int LIMIT_CFG  = 100,
  parameter int MARGIN_MUL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_word,
  input  logic [DATA_W-1:0] exp_data,
  output logic [1:0]        supply_lvl,
  output logic              prog_pulse,
  output logic              rd_req,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err_code
);
  localparam int LIM_TOP = (LIMIT_CFG > LIMIT_STD) ? LIMIT_CFG : LIMIT_STD;
  localparam int CNT_W   = $clog2(LIM_TOP + 1);
  localparam int MRG_W   = $clog2(MARGIN_MUL * LIM_TOP + 1);
  localparam int TMR_MAX = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] PULSE_LD  = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] LIM_S     = CNT_W'(LIMIT_STD);
  localparam logic [CNT_W-1:0] LIM_C     = CNT_W'(LIMIT_CFG);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  st_e               st_q, st_d;
  lvl_e              lvl_q, lvl_d;
  err_e              err_q, err_d;
  logic              cfg_q;
  logic [DATA_W-1:0] exp_q;
  logic              rdq_q, rdq_d;
  logic              lat_en;
  logic              tmr_load, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;
  logic              cnt_clr, cnt_inc, mrg_load, mrg_dec, mrg_zero;
  logic [CNT_W-1:0]  pulse_cnt;
  logic [CNT_W-1:0]  limit;

  eprom_seq_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_sync), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_exp)
  );

  eprom_seq_tally #(.CNT_W(CNT_W), .MRG_W(MRG_W), .MARGIN_MUL(MARGIN_MUL)) u_tally (
    .clk(clk), .rst_n(rst_sync), .clr(cnt_clr), .inc(cnt_inc),
    .mrg_load(mrg_load), .mrg_dec(mrg_dec), .cnt(pulse_cnt), .mrg_zero(mrg_zero)
  );

  assign limit = cfg_q ? LIM_C : LIM_S;

  always_comb begin
    st_d     = st_q;
    lvl_d    = lvl_q;
    err_d    = err_q;
    lat_en   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = SETTLE_LD;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    mrg_load = 1'b0;
    mrg_dec  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        lat_en = 1'b1; cnt_clr = 1'b1; err_d = ERR_NONE;
        lvl_d = LVL_MIN; tmr_load = 1'b1; st_d = ST_SET_BLANK;
      end
      ST_SET_BLANK: if (tmr_exp) st_d = ST_RD_BLANK;
      ST_RD_BLANK: if (rd_valid) begin
        if (rd_data == '1) begin
          lvl_d = LVL_PROG; tmr_load = 1'b1; st_d = ST_SET_PROG;
        end else begin
          err_d = ERR_BLANK; st_d = ST_DONE;
        end
      end
      ST_SET_PROG: if (tmr_exp) begin
        tmr_load = 1'b1; tmr_val = PULSE_LD; st_d = ST_PULSE;
      end
      ST_PULSE: if (tmr_exp) begin
        cnt_inc = 1'b1; st_d = ST_RD_VFY;
      end
      ST_RD_VFY: if (rd_valid) begin
        if (rd_data == exp_q) begin
          mrg_load = 1'b1; tmr_load = 1'b1; tmr_val = PULSE_LD; st_d = ST_MRG_PULSE;
        end else if (pulse_cnt >= limit) begin
          err_d = ERR_UNPROG; st_d = ST_DONE;
        end else begin
          tmr_load = 1'b1; tmr_val = PULSE_LD; st_d = ST_PULSE;
        end
      end
      ST_MRG_PULSE: if (tmr_exp) begin
        mrg_dec = 1'b1; st_d = ST_MRG_GAP;
      end
      ST_MRG_GAP: begin
        tmr_load = 1'b1;
        if (mrg_zero) begin
          lvl_d = LVL_MIN; st_d = ST_SET_MIN;
        end else begin
          tmr_val = PULSE_LD; st_d = ST_MRG_PULSE;
        end
      end
      ST_SET_MIN: if (tmr_exp) st_d = ST_RD_MIN;
      ST_RD_MIN: if (rd_valid) begin
        if (rd_data == exp_q) begin
          lvl_d = LVL_MAX; tmr_load = 1'b1; st_d = ST_SET_MAX;
        end else begin
          err_d = ERR_MARGIN; st_d = ST_DONE;
        end
      end
      ST_SET_MAX: if (tmr_exp) st_d = ST_RD_MAX;
      ST_RD_MAX: if (rd_valid) begin
        if (rd_data != exp_q) err_d = ERR_MARGIN;
        st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign rdq_d = (st_d != st_q) &&
                 (st_d == ST_RD_BLANK || st_d == ST_RD_VFY ||
                  st_d == ST_RD_MIN   || st_d == ST_RD_MAX);

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      st_q  <= ST_IDLE;
      lvl_q <= LVL_MIN;
      err_q <= ERR_NONE;
      rdq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
      err_q <= err_d;
      rdq_q <= rdq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      cfg_q <= 1'b0;
      exp_q <= '0;
    end else if (lat_en) begin
      cfg_q <= cfg_word;
      exp_q <= exp_data;
    end
  end

  assign supply_lvl = lvl_q;
  assign prog_pulse = (st_q == ST_PULSE) || (st_q == ST_MRG_PULSE);
  assign rd_req     = rdq_q;
  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_DONE);
  assign err_code   = done ? err_q : ERR_NONE;
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
  parameter int PULSE_CYC  = 2000,
  parameter int SETTLE_CYC = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] supply_lvl,
  input logic       prog_pulse,
  input logic       rd_req,
  input logic       busy,
  input logic       done,
  input logic [1:0] err_code
);
  localparam int AGE_W = $clog2(SETTLE_CYC + 1) + 1;
  localparam int WID_W = $clog2(PULSE_CYC + 1) + 1;

  logic [AGE_W-1:0] age_q;
  logic [WID_W-1:0] wid_q;
  logic [1:0]       lvl_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q      <= '0;
      lvl_prev_q <= 2'd0;
      wid_q      <= '0;
    end else begin
      lvl_prev_q <= supply_lvl;
      if (supply_lvl != lvl_prev_q)            age_q <= '0;
      else if (age_q < AGE_W'(SETTLE_CYC))     age_q <= age_q + 1'b1;
      if (prog_pulse)                          wid_q <= wid_q + 1'b1;
      else                                     wid_q <= '0;
    end
  end

  a_r2_pulse_at_prog: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |-> supply_lvl == 2'd1);
  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_pulse) |-> wid_q == WID_W'(PULSE_CYC));
  a_r5_pass_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd0) |-> supply_lvl == 2'd2);
  a_r6_settle_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> age_q >= AGE_W'(SETTLE_CYC - 1));
  a_r6_settle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_pulse) |-> age_q >= AGE_W'(SETTLE_CYC - 1));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> err_code == 2'd0);
  a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  a_r8_req_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && prog_pulse));
  a_r9_activity_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_pulse || rd_req || done) |-> busy);
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
  .PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_lvl(supply_lvl), .prog_pulse(prog_pulse),
  .rd_req(rd_req), .busy(busy), .done(done), .err_code(err_code)
);

// File: tb/eprom_prog_seq_tb.sv
`timescale 1ns/1ps
module eprom_prog_seq_tb;
  localparam int DW     = 16;
  localparam int PULSE  = 4;
  localparam int SETTLE = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, cfg_word, rd_valid;
  logic [DW-1:0] exp_data, rd_data;
  logic [1:0]    supply_lvl, err_code;
  logic          prog_pulse, rd_req, busy, done;

  always #2.5 clk = ~clk;

  eprom_prog_seq #(.DATA_W(DW), .PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word),
    .exp_data(exp_data), .supply_lvl(supply_lvl), .prog_pulse(prog_pulse),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .done(done), .err_code(err_code)
  );

  int checks = 0, fails = 0;
  // target model and monitor state
  int m_need, m_mode;
  logic [DW-1:0] m_exp;
  int pulses, reads, prog_reads, done_cnt, width_bad, lvl_bad, settle_bad;
  int first_lvl, last_lvl, err_seen, age, wcnt;
  logic [1:0] lvl_prev;
  logic pp_prev;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  initial begin
    age = 0; wcnt = 0; lvl_prev = 2'd0; pp_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (supply_lvl != lvl_prev) age = 0; else if (age < 1000) age++;
      lvl_prev = supply_lvl;
      if (prog_pulse) begin
        if (!pp_prev) begin
          pulses++;
          if (supply_lvl != 2'd1) lvl_bad++;
          if (age < SETTLE) settle_bad++;
        end
        wcnt++;
      end else begin
        if (pp_prev && wcnt != PULSE) width_bad++;
        wcnt = 0;
      end
      pp_prev = prog_pulse;
      if (rd_req) begin
        if (reads == 0) first_lvl = supply_lvl;
        if (supply_lvl == 2'd1) prog_reads++;
        last_lvl = supply_lvl;
        reads++;
        if (age < SETTLE) settle_bad++;
      end
      if (done) begin
        done_cnt++;
        err_seen = err_code;
      end
    end
  end

  initial begin
    logic [DW-1:0] d;
    rd_valid = 1'b0; rd_data = '0;
    forever begin
      @(negedge clk);
      if (rd_req) begin
        if (pulses == 0)                          d = (m_mode == 1) ? 16'hFFFE : 16'hFFFF;
        else if (pulses < m_need)                 d = 16'hFFFF;
        else if (m_mode == 2 && supply_lvl == 0)  d = m_exp ^ 16'h0100;
        else if (m_mode == 3 && supply_lvl == 2)  d = m_exp ^ 16'h0001;
        else                                      d = m_exp;
        @(negedge clk);
        @(negedge clk);
        rd_valid = 1'b1; rd_data = d;
        @(negedge clk);
        rd_valid = 1'b0;
      end
    end
  end

  // mode: 0 normal, 1 not blank, 2 bad at min, 3 bad at max
  task automatic run_loc(input bit cfg, input int need, input int mode, input bit poke);
    int lim, e_err, e_pulses, e_reads, e_prog, e_last;
    lim = cfg ? 100 : 25;
    @(negedge clk);
    m_need = need; m_mode = mode;
    m_exp = 16'h5A3C ^ 16'(need << 4);
    pulses = 0; reads = 0; prog_reads = 0; done_cnt = 0;
    width_bad = 0; lvl_bad = 0; settle_bad = 0; first_lvl = -1; last_lvl = -1;
    cfg_word = cfg; exp_data = m_exp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; cfg_word = !cfg; exp_data = ~m_exp;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (6) @(negedge clk);
    if (mode == 1) begin
      e_err = 1; e_pulses = 0; e_reads = 1; e_prog = 0; e_last = 0;
    end else if (need > lim) begin
      e_err = 2; e_pulses = lim; e_reads = lim + 1; e_prog = lim; e_last = 1;
    end else begin
      e_pulses = 4 * need; e_prog = need;
      e_err = (mode == 0) ? 0 : 3;
      e_reads = (mode == 2) ? need + 2 : need + 3;
      e_last = (mode == 2) ? 0 : 2;
    end
    chk(err_seen == e_err, poke ? "R9 result code under ignored start" :
        (mode == 1 ? "R1 blank result code" : (e_err == 2 ? "R3 limit result code" :
        (mode != 0 ? "R5 margin result code" : "R4 pass result code"))), err_seen, e_err);
    chk(pulses == e_pulses, e_err == 2 ? "R3 pulse total at limit" : "R4 pulse total 4N", pulses, e_pulses);
    chk(reads == e_reads, "R5 read count", reads, e_reads);
    chk(prog_reads == e_prog, "R2 verify reads at prog level", prog_reads, e_prog);
    chk(last_lvl == e_last, "R5 level of last read", last_lvl, e_last);
    chk(first_lvl == 0, "R1 blank read at min level", first_lvl, 0);
    chk(done_cnt == 1, "R7 single done strobe", done_cnt, 1);
    chk(width_bad == 0 && lvl_bad == 0, "R2 pulse width and level", width_bad + lvl_bad, 0);
    chk(settle_bad == 0, "R6 settle before read or pulse", settle_bad, 0);
    chk(busy == 1'b0 && err_code == 2'd0, "R7 quiet code after done", err_code, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_word = 1'b0; exp_data = '0;
    m_need = 1; m_mode = 0; m_exp = '0;
    pulses = 0; reads = 0; prog_reads = 0; done_cnt = 0;
    width_bad = 0; lvl_bad = 0; settle_bad = 0; err_seen = 0;
    first_lvl = -1; last_lvl = -1;
    repeat (3) @(negedge clk);
    chk(supply_lvl == 2'd0, "R10 reset level", supply_lvl, 0);
    chk(!busy && !done && !prog_pulse && !rd_req && err_code == 2'd0,
        "R10 reset outputs idle", {busy, done, prog_pulse, rd_req}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(supply_lvl == 2'd0 && !busy, "R10 idle after release", supply_lvl, 0);
    for (int n = 1; n <= 27; n++) run_loc(1'b0, n, 0, 1'b0);
    run_loc(1'b1, 1, 0, 1'b0);
    run_loc(1'b1, 26, 0, 1'b0);
    run_loc(1'b1, 99, 0, 1'b0);
    run_loc(1'b1, 100, 0, 1'b0);
    run_loc(1'b1, 101, 0, 1'b0);
    run_loc(1'b0, 5, 1, 1'b0);
    run_loc(1'b1, 5, 1, 1'b0);
    run_loc(1'b0, 3, 2, 1'b0);
    run_loc(1'b0, 5, 3, 1'b0);
    run_loc(1'b1, 7, 2, 1'b0);
    run_loc(1'b0, 4, 0, 1'b1);
    run_loc(1'b0, 30, 0, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule